// File: doc/BRIEF.md
# Codec Host Register Port with Resync Lockout

This block is the host-facing register port of a codec control core. The host sees two byte locations. The first is a pointer register. It holds a pointer to one of several internal registers and a flag that permits clock-setting changes. The second is a data window onto whichever internal register the pointer selects. One of those internal registers is the format register. Its low nibble carries the clock selection: a three-bit divider code and a one-bit clock-source select.

The clock selection that the rest of the core uses is held separately as the active setting. It changes only through a resynchronisation interval. A format write starts that interval only when the change-permit flag is set and the written clock bits differ from the active setting. The interval lasts a fixed, parameterised number of core clocks. Until it ends, the port discards every host write and answers every read with the busy code 0x80. The host polls the pointer location until the answer is no longer 0x80, and may then clear the change-permit flag. The real clock switching and the meaning of the other registers lie outside this block.

Top module: `codec_host_port`

## Requirements
- R1: After reset, the pointer location reads 0x00, every internal register holds 0x00, the active divider code and source select are 0, and the busy output is low.
- R2: A write to the pointer location (address 0) stores bit 6 as the change-permit flag and bits 3:0 as the register pointer. Outside resync, reads of that location return these two fields, with bits 7, 5 and 4 reading 0.
- R3: Outside resync, a write to the data location (address 1) stores the byte in the internal register that the pointer selects, and a read of the data location returns that register.
- R4: The format register sits at pointer 8. A write to it starts resync when two conditions hold: the change-permit flag is set, and the clock bits written differ from the active setting. The clock bits are bits 3:1 for the divider code and bit 0 for the source select. The busy output is then high for exactly RESYNC_CYC clock cycles, counted from the cycle after the write.
- R5: While the busy output is high, every read returns 0x80, at either address.
- R6: While the busy output is high, host writes to either address have no effect.
- R7: When resync ends, the active setting takes the clock bits of the format register. From the first cycle with busy low, reads return the true register values.
- R8: A format write made while the change-permit flag is clear is stored but starts no resync and leaves the active setting unchanged.
- R9: A format write with the flag set, whose clock bits equal the active setting, is stored (data-format bits included) and starts no resync.
- R10: After resync, clearing the change-permit flag through the pointer location leaves the active setting unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 1 | 0 selects the pointer location, 1 selects the data window |
| host_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the addressed location, combinational |
| rsync_busy | output | 1 | High during the resync interval |
| act_div | output | 3 | Active clock divider code |
| act_base | output | 1 | Active clock source select |

## Verification
The bench counts the busy window edge by edge. A counter one cycle short or one cycle long shows up as a true value read where 0x80 was due, or the reverse. It injects writes to both locations inside the window. A lockout that misses either path would leave a changed pointer or format register once busy drops. It also writes the clock bits with the change-permit flag clear. A design that acted on them at once would move the active setting or raise busy. Finally, it rewrites only the data-format bits with the flag set. A design that compared whole bytes instead of the clock bits would start a needless resync.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned PERMIT_BIT = 6;
  localparam logic [BYTE_W-1:0] BUSY_CODE = 8'h80;

  typedef struct packed {
    logic [2:0] div;
    logic       base;
  } clk_sel_t;

  // Extract the clock selection from the low nibble of a format byte.
  function automatic clk_sel_t fmt_clk(input logic [3:0] nib);
    clk_sel_t s;
    s.div  = nib[3:1];
    s.base = nib[0];
    return s;
  endfunction

  function automatic logic clk_differs(input clk_sel_t a, input clk_sel_t b);
    return (a.div != b.div) || (a.base != b.base);
  endfunction

endpackage

// File: rtl/hrp_index_reg.sv
module hrp_index_reg #(
  parameter int unsigned IDX_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         permit_in,
  input  logic [IDX_W-1:0]             ptr_in,
  output logic                         permit_q,
  output logic [IDX_W-1:0]             ptr_q,
  output logic [hrp_pkg::BYTE_W-1:0]   rd_val
);
  import hrp_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      permit_q <= 1'b0;
      ptr_q    <= '0;
    end else if (wr_en) begin
      permit_q <= permit_in;
      ptr_q    <= ptr_in;
    end
  end

  always_comb begin
    rd_val             = '0;
    rd_val[IDX_W-1:0]  = ptr_q;
    rd_val[PERMIT_BIT] = permit_q;
  end

endmodule

// File: rtl/hrp_reg_bank.sv
module hrp_reg_bank #(
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned FMT_IDX = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             ptr,
  input  logic [hrp_pkg::BYTE_W-1:0]   wdata,
  output logic [hrp_pkg::BYTE_W-1:0]   rd_val,
  output logic [hrp_pkg::BYTE_W-1:0]   fmt_val
);
  import hrp_pkg::*;

  localparam int unsigned NREG = 1 << IDX_W;

  logic [BYTE_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_en && (ptr == IDX_W'(g)))
        regs[g] <= wdata;
    end
  end

  assign rd_val  = regs[ptr];
  assign fmt_val = regs[FMT_IDX];

endmodule

// File: rtl/hrp_resync_timer.sv
module hrp_resync_timer #(
  parameter int unsigned RESYNC_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = $clog2(RESYNC_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (start)
      cnt_q <= CW'(RESYNC_CYC);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - CW'(1);
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1));

endmodule

// File: rtl/codec_host_port.sv
module codec_host_port #(
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned FMT_IDX    = 8,
  parameter int unsigned RESYNC_CYC = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_addr,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       rsync_busy,
  output logic [2:0] act_div,
  output logic       act_base
);
  import hrp_pkg::*;

  logic              busy;
  logic              done_pulse;
  logic              start_pulse;
  logic              wr_ok;
  logic              idx_we;
  logic              dat_we;
  logic              permit;
  logic [IDX_W-1:0]  ptr;
  logic [BYTE_W-1:0] idx_rd;
  logic [BYTE_W-1:0] bank_rd;
  logic [BYTE_W-1:0] fmt_q;
  logic              fmt_hit;
  clk_sel_t          active_q;
  clk_sel_t          wr_sel;
  clk_sel_t          fmt_sel;

  // Lockout: no write reaches storage while resync runs.
  assign wr_ok  = host_wr && !busy;
  assign idx_we = wr_ok && !host_addr;
  assign dat_we = wr_ok &&  host_addr;

  hrp_index_reg #(.IDX_W(IDX_W)) u_index (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (idx_we),
    .permit_in (host_wdata[PERMIT_BIT]),
    .ptr_in    (host_wdata[IDX_W-1:0]),
    .permit_q  (permit),
    .ptr_q     (ptr),
    .rd_val    (idx_rd)
  );

  hrp_reg_bank #(.IDX_W(IDX_W), .FMT_IDX(FMT_IDX)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (dat_we),
    .ptr     (ptr),
    .wdata   (host_wdata),
    .rd_val  (bank_rd),
    .fmt_val (fmt_q)
  );

  assign fmt_hit     = (ptr == IDX_W'(FMT_IDX));
  assign wr_sel      = fmt_clk(host_wdata[3:0]);
  assign fmt_sel     = fmt_clk(fmt_q[3:0]);
  assign start_pulse = dat_we && fmt_hit && permit && clk_differs(wr_sel, active_q);

  hrp_resync_timer #(.RESYNC_CYC(RESYNC_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_pulse),
    .busy  (busy),
    .done  (done_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      active_q <= '0;
    else if (done_pulse)
      active_q <= fmt_sel;
  end

  always_comb begin
    if (busy)
      host_rdata = BUSY_CODE;
    else if (host_addr)
      host_rdata = bank_rd;
    else
      host_rdata = idx_rd;
  end

  assign rsync_busy = busy;
  assign act_div    = active_q.div;
  assign act_base   = active_q.base;

endmodule

// File: rtl/hrp_checker.sv
module hrp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       host_addr,
  input logic       host_wr,
  input logic [7:0] host_rdata,
  input logic       busy,
  input logic       start_pulse,
  input logic       done_pulse,
  input logic       permit,
  input logic [7:0] fmt_q,
  input logic [7:0] idx_rd,
  input logic [2:0] act_div,
  input logic       act_base
);

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> busy);

  // R8
  start_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> permit);

  // R5
  busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (host_rdata == 8'h80));

  // R6
  lock_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr) |=> $stable(fmt_q));

  // R6
  lock_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr) |=> $stable(idx_rd));

  // R7
  done_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> ({act_div, act_base} == $past(fmt_q[3:0])));

  // R8
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_pulse |=> ($stable(act_div) && $stable(act_base)));

  // R2
  idx_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !host_addr) |-> (host_rdata[7] == 1'b0));

endmodule

bind codec_host_port hrp_checker u_hrp_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_addr   (host_addr),
  .host_wr     (host_wr),
  .host_rdata  (host_rdata),
  .busy        (busy),
  .start_pulse (start_pulse),
  .done_pulse  (done_pulse),
  .permit      (permit),
  .fmt_q       (fmt_q),
  .idx_rd      (idx_rd),
  .act_div     (act_div),
  .act_base    (act_base)
);

// File: tb/test_codec_host_port.sv
module test_codec_host_port;

  localparam int unsigned NCYC = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_addr = 1'b0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       rsync_busy;
  logic [2:0] act_div;
  logic       act_base;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #2.5 clk = ~clk;

  codec_host_port #(.IDX_W(4), .FMT_IDX(8), .RESYNC_CYC(NCYC)) i_codec_host_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .rsync_busy (rsync_busy),
    .act_div    (act_div),
    .act_base   (act_base)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Call at a falling edge; rdata is combinational.
  task automatic chk_read(input logic a, input logic [7:0] exp, input string req, input string what);
    host_addr = a;
    #0.5;
    check(req, what, int'(host_rdata), int'(exp));
  endtask

  task automatic hwrite(input logic a, input logic [7:0] d);
    @(negedge clk);
    host_addr  = a;
    host_wdata = d;
    host_wr    = 1'b1;
    @(negedge clk);
    host_wr    = 1'b0;
  endtask

  task automatic chk_act(input logic [2:0] d, input logic b, input string req);
    check(req, "act_div", int'(act_div), int'(d));
    check(req, "act_base", int'(act_base), int'(b));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk_read(1'b0, 8'h00, "R1", "pointer after reset");
    chk_read(1'b1, 8'h00, "R1", "reg0 after reset");
    check("R1", "busy after reset", int'(rsync_busy), 0);
    chk_act(3'd0, 1'b0, "R1");
  endtask

  task automatic t_index_rw;
    hwrite(1'b0, 8'hF5);   // permit=1, ptr=5; bits 7,5,4 dropped
    chk_read(1'b0, 8'h45, "R2", "pointer fields");
    hwrite(1'b0, 8'h03);
    chk_read(1'b0, 8'h03, "R2", "pointer permit cleared");
  endtask

  task automatic t_data_rw;
    hwrite(1'b0, 8'h03);
    hwrite(1'b1, 8'hA5);
    hwrite(1'b0, 8'h0C);
    hwrite(1'b1, 8'h3C);
    chk_read(1'b1, 8'h3C, "R3", "reg12");
    hwrite(1'b0, 8'h03);
    chk_read(1'b1, 8'hA5, "R3", "reg3");
    hwrite(1'b0, 8'h02);
    chk_read(1'b1, 8'h00, "R3", "reg2 untouched");
  endtask

  task automatic t_fmt_no_permit;
    hwrite(1'b0, 8'h08);
    hwrite(1'b1, 8'h07);   // div=3, base=1, permit clear
    check("R8", "busy after write", int'(rsync_busy), 0);
    chk_read(1'b1, 8'h07, "R8", "format stored");
    chk_act(3'd0, 1'b0, "R8");
  endtask

  task automatic t_resync;
    hwrite(1'b0, 8'h48);   // permit=1, ptr=8
    hwrite(1'b1, 8'h2D);   // div=6, base=1
    for (int i = 0; i < NCYC; i++) begin
      check("R4", "busy in window", int'(rsync_busy), 1);
      chk_read(1'b0, 8'h80, "R5", "pointer during resync");
      chk_read(1'b1, 8'h80, "R5", "data during resync");
      if (i == 2) begin
        host_addr = 1'b0; host_wdata = 8'h03; host_wr = 1'b1;
      end
      if (i == NCYC - 1) begin
        host_addr = 1'b1; host_wdata = 8'hFF; host_wr = 1'b1;
      end
      @(negedge clk);
      host_wr = 1'b0;
    end
    check("R4", "busy after window", int'(rsync_busy), 0);
    chk_read(1'b0, 8'h48, "R6", "pointer write ignored");
    chk_read(1'b1, 8'h2D, "R6", "format write ignored");
    chk_act(3'd6, 1'b1, "R7");
  endtask

  task automatic t_same_clock;
    hwrite(1'b1, 8'hAD);   // only data-format bits differ
    check("R9", "no busy", int'(rsync_busy), 0);
    chk_read(1'b1, 8'hAD, "R9", "format stored");
    chk_act(3'd6, 1'b1, "R9");
  endtask

  task automatic t_clear_permit;
    hwrite(1'b0, 8'h08);
    chk_read(1'b0, 8'h08, "R10", "permit cleared");
    check("R10", "no busy", int'(rsync_busy), 0);
    chk_act(3'd6, 1'b1, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_index_rw();
    t_data_rw();
    t_fmt_no_permit();
    t_resync();
    t_same_clock();
    t_clear_permit();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule